// File: doc/BRIEF.md
# DRAM Refresh Command Sequencer

This block converts a single refresh request into the control-pin activity a DRAM device expects for one refresh operation. A requester presents a request with a valid/ready handshake. A mode bit selects one of two refresh styles.

In row-addressed mode the request carries a row number. The sequencer places that row on the address bus one cycle ahead of the row strobe and keeps it there until the strobe rises again. In counter-based mode no row is supplied. The sequencer drops the column strobe one cycle ahead of the row strobe, keeps write-enable high, and the device selects the row from its own internal counter.

A cycle-level model of the device-side row counter sits inside the top module and is exposed on ports. It lets a user, or a bench, watch which row each refresh touches. The busy time of one operation is set by a parameter, so that the hold time of ready matches the refresh time of the device.

Top module: `rfsh_cmd_seq`

## Requirements
- R1: After reset the outputs are as follows: `req_ready`=1, `ras_n`=1, `cas_n`=1, `we_n`=1, `addr`=0, `dev_row_ptr`=0 and `dev_last_row`=0.
- R2: A request is accepted on a clock edge where `req_valid`=1 and `req_ready`=1. From the next cycle, `req_ready` stays 0 for exactly `OP_CYCLES` cycles and then returns to 1.
- R3: In row-addressed mode (`req_mode`=0), `addr` equals the requested row from the first busy cycle up to the last busy cycle. `ras_n` is 0 during busy cycles 2 to `OP_CYCLES`-1, counting the first busy cycle as 1. `cas_n` stays 1.
- R4: In counter-based mode (`req_mode`=1), `cas_n` is 0 during busy cycles 1 to `OP_CYCLES`-1. `ras_n` is 0 during busy cycles 2 to `OP_CYCLES`-1, so the column strobe always falls one cycle before the row strobe. `addr` stays 0.
- R5: `we_n` is 1 in every cycle, in both modes.
- R6: On each falling edge of `ras_n`, the device model acts by mode:
  - when `cas_n` is low, `dev_last_row` takes the old `dev_row_ptr` and `dev_row_ptr` advances by one;
  - when `cas_n` is high, `dev_last_row` takes `addr` and `dev_row_ptr` is unchanged.
- R7: `dev_row_ptr` wraps from `ROWS`-1 to 0 on a counter-based refresh and never exceeds `ROWS`-1.
- R8: In the last busy cycle, `ras_n` and `cas_n` are both 1. Neither strobe is ever low while `req_ready`=1.
- R9: While `req_ready`=0, a request is not taken, and changes on `req_row` do not reach `addr`. A request held high is accepted on the first edge where `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Refresh request present |
| req_ready | output | 1 | Sequencer idle; a request is taken on this edge |
| req_mode | input | 1 | 0 = row-addressed, 1 = counter-based |
| req_row | input | ROW_W | Row to refresh in row-addressed mode |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low, held high |
| addr | output | ROW_W | Row address bus |
| dev_row_ptr | output | ROW_W | Device model internal refresh row counter |
| dev_last_row | output | ROW_W | Row touched by the latest refresh in the model |

## Verification
Two actions can fall on the same clock edge. One is the return of `req_ready` at the end of an operation; the other is the acceptance of a request that has been waiting since the middle of that operation. The bench raises a second request, with a different row, while the first is still strobing. It then checks three things:
- `addr` keeps the first row through recovery;
- `req_ready` is high for exactly one sampled cycle;
- the second row reaches `addr` on the very next cycle, and the model records both rows in order.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_RECOV  = 2'd3
  } rf_state_e;

  localparam logic MODE_ROW = 1'b0;
  localparam logic MODE_CTR = 1'b1;

endpackage

// File: rtl/rfsh_rst_sync.sv
module rfsh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/rfsh_fsm.sv
module rfsh_fsm
  import rfsh_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int OP_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_mode,
  input  logic [ROW_W-1:0] req_row,
  output logic             req_ready,
  output rf_state_e        state_d,
  output logic             mode_d,
  output logic [ROW_W-1:0] row_d
);

  localparam int STROBE_CYC = OP_CYCLES - 2;
  localparam int CNT_W      = $clog2(STROBE_CYC + 1) + 1;

  rf_state_e        state_q;
  logic             mode_q;
  logic [ROW_W-1:0] row_q;
  logic             cap_en;
  logic             tmr_load;
  logic             tmr_zero;

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    row_d    = row_q;
    cap_en   = 1'b0;
    tmr_load = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          cap_en  = 1'b1;
          mode_d  = req_mode;
          row_d   = (req_mode == MODE_ROW) ? req_row : '0;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        state_d  = ST_STROBE;
      end
      ST_STROBE: begin
        if (tmr_zero) begin
          state_d = ST_RECOV;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ROW;
      row_q  <= '0;
    end else if (cap_en) begin
      mode_q <= mode_d;
      row_q  <= row_d;
    end
  end

  rfsh_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (CNT_W'(STROBE_CYC - 1)),
    .run      (state_q == ST_STROBE),
    .zero     (tmr_zero)
  );

  assign req_ready = (state_q == ST_IDLE);

  // R9
  held_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(row_q));

endmodule

// File: rtl/rfsh_pin_drv.sv
module rfsh_pin_drv
  import rfsh_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rf_state_e        state_d,
  input  logic             mode_d,
  input  logic [ROW_W-1:0] row_d,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr
);

  logic             ras_n_d, cas_n_d;
  logic [ROW_W-1:0] addr_d;

  always_comb begin
    ras_n_d = (state_d != ST_STROBE);
    cas_n_d = !((mode_d == MODE_CTR) &&
                ((state_d == ST_SETUP) || (state_d == ST_STROBE)));
    addr_d  = ((mode_d == MODE_ROW) && (state_d != ST_IDLE)) ? row_d : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      addr  <= '0;
    end else begin
      ras_n <= ras_n_d;
      cas_n <= cas_n_d;
      addr  <= addr_d;
    end
  end

  assign we_n = 1'b1;

  // R3
  addr_setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> $stable(addr));

  // R4
  cas_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> !$past(cas_n));

  // R4
  cas_not_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ras_n);

endmodule

// File: rtl/rfsh_dev_model.sv
module rfsh_dev_model #(
  parameter int ROW_W = 14,
  parameter int ROWS  = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] row_ptr,
  output logic [ROW_W-1:0] last_row
);

  localparam logic [ROW_W-1:0] LAST_IDX = ROW_W'(ROWS - 1);

  logic             ras_prev_q;
  logic             ras_fall;
  logic             ptr_en;
  logic             last_en;
  logic [ROW_W-1:0] ptr_d, last_d;

  assign ras_fall = ras_prev_q && !ras_n;

  always_comb begin
    ptr_en  = 1'b0;
    last_en = 1'b0;
    ptr_d   = row_ptr;
    last_d  = last_row;
    if (ras_fall) begin
      last_en = 1'b1;
      if (!cas_n) begin
        ptr_en = 1'b1;
        last_d = row_ptr;
        ptr_d  = (row_ptr == LAST_IDX) ? '0 : row_ptr + 1'b1;
      end else begin
        last_d = addr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev_q <= 1'b1;
    end else begin
      ras_prev_q <= ras_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_ptr <= '0;
    end else if (ptr_en) begin
      row_ptr <= ptr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_row <= '0;
    end else if (last_en) begin
      last_row <= last_d;
    end
  end

  // R7
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_ptr <= LAST_IDX);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_fall && cas_n) |=> $stable(row_ptr));

endmodule

// File: rtl/rfsh_cmd_seq.sv
module rfsh_cmd_seq
  import rfsh_pkg::*;
#(
  parameter int ROW_W     = 14,
  parameter int ROWS      = 16384,
  parameter int OP_CYCLES = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_mode,
  input  logic [ROW_W-1:0] req_row,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [ROW_W-1:0] addr,
  output logic [ROW_W-1:0] dev_row_ptr,
  output logic [ROW_W-1:0] dev_last_row
);

  localparam int BUSY_W = $clog2(OP_CYCLES + 1) + 1;

  logic             rst_sync_n;
  rf_state_e        state_d;
  logic             mode_d;
  logic [ROW_W-1:0] row_d;

  rfsh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rfsh_fsm #(.ROW_W(ROW_W), .OP_CYCLES(OP_CYCLES)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_row   (req_row),
    .req_ready (req_ready),
    .state_d   (state_d),
    .mode_d    (mode_d),
    .row_d     (row_d)
  );

  rfsh_pin_drv #(.ROW_W(ROW_W)) u_pins (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .state_d (state_d),
    .mode_d  (mode_d),
    .row_d   (row_d),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .addr    (addr)
  );

  rfsh_dev_model #(.ROW_W(ROW_W), .ROWS(ROWS)) u_model (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .addr     (addr),
    .row_ptr  (dev_row_ptr),
    .last_row (dev_last_row)
  );

  logic [BUSY_W-1:0] busy_len_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_len_q <= '0;
    end else if (req_ready) begin
      busy_len_q <= '0;
    end else begin
      busy_len_q <= busy_len_q + 1'b1;
    end
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req_ready) |-> (busy_len_q == BUSY_W'(OP_CYCLES)));

  // R8
  idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_ready |-> (ras_n && cas_n));

  // R8
  recovery_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(req_ready) |-> ($past(ras_n) && $past(cas_n)));

  // R5
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    we_n);

endmodule

// File: tb/tb_rfsh_cmd_seq.sv
module tb_rfsh_cmd_seq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W      = 8;
  localparam int ROWS       = 5;
  localparam int OP         = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic             req_ready;
  logic             req_mode;
  logic [ROW_W-1:0] req_row;
  logic             ras_n, cas_n, we_n;
  logic [ROW_W-1:0] addr, dev_row_ptr, dev_last_row;

  int errors = 0;
  int checks = 0;
  int exp_ptr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rfsh_cmd_seq #(.ROW_W(ROW_W), .ROWS(ROWS), .OP_CYCLES(OP)) dut (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_mode (req_mode), .req_row (req_row), .ras_n (ras_n), .cas_n (cas_n),
    .we_n (we_n), .addr (addr), .dev_row_ptr (dev_row_ptr),
    .dev_last_row (dev_last_row)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_mode = 1'b0; req_row = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", req_ready, 1);
    chk("R1 ras_n", ras_n, 1);
    chk("R1 cas_n", cas_n, 1);
    chk("R1 we_n", we_n, 1);
    chk("R1 addr", addr, 0);
    chk("R1 ptr", dev_row_ptr, 0);
    chk("R1 last", dev_last_row, 0);
    exp_ptr = 0;
  endtask

  // One operation, sampled on negedges; busy cycle j=1..OP, j=OP+1 idle.
  // pend: a second row-mode request for prow is raised in busy cycle 3.
  task automatic run_op(input logic mode, input int row, input bit pend,
                        input int prow);
    int exp_last;
    req_valid = 1'b1; req_mode = mode; req_row = ROW_W'(row);
    @(negedge clk);
    req_valid = 1'b0;
    for (int j = 1; j <= OP + 1; j++) begin
      if (j > 1) @(negedge clk);
      if (pend && j == 3) begin
        req_valid = 1'b1; req_mode = 1'b0; req_row = ROW_W'(prow);
      end
      if (j <= OP) begin
        chk("R2 ready low", req_ready, 0);
        chk("R5 we_n", we_n, 1);
        chk("R3/R4 ras_n", ras_n, (j >= 2 && j <= OP - 1) ? 0 : 1);
        if (mode) begin
          chk("R4 cas_n", cas_n, (j <= OP - 1) ? 0 : 1);
          chk("R4 addr", addr, 0);
        end else begin
          chk("R3 cas_n", cas_n, 1);
          chk(pend ? "R9 addr held" : "R3 addr", addr, row);
        end
        if (j == OP) begin
          chk("R8 recovery ras", ras_n, 1);
          chk("R8 recovery cas", cas_n, 1);
        end
      end else begin
        chk("R2 ready back", req_ready, 1);
      end
    end
    if (mode) begin
      exp_last = exp_ptr;
      exp_ptr  = (exp_ptr == ROWS - 1) ? 0 : exp_ptr + 1;
    end else begin
      exp_last = row;
    end
    chk("R6 last row", dev_last_row, exp_last);
    chk("R6/R7 ptr", dev_row_ptr, exp_ptr);
    if (pend) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 pending taken", req_ready, 0);
      chk("R9 new addr", addr, prow);
      repeat (OP) @(negedge clk);
      chk("R9 ready", req_ready, 1);
      chk("R9 last row", dev_last_row, prow);
      chk("R9 ptr", dev_row_ptr, exp_ptr);
    end
  endtask

  task automatic t_row();
    run_op(1'b0, 8'hA5, 1'b0, 0);
    run_op(1'b0, 3, 1'b0, 0);
  endtask

  task automatic t_ctr();
    run_op(1'b1, 8'hFF, 1'b0, 0);
    run_op(1'b1, 0, 1'b0, 0);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < ROWS + 1; i++) run_op(1'b1, 0, 1'b0, 0);
    chk("R7 wrapped ptr", dev_row_ptr, exp_ptr);
  endtask

  task automatic t_busy();
    run_op(1'b0, 8'h3C, 1'b1, 8'hC3);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_row();
    t_ctr();
    t_wrap();
    t_busy();
    t_row();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule